// File: doc/BRIEF.md
# Row-Mapping Toffoli Gate Generator

This block takes a source bit pattern and a destination bit pattern of the same width, where the source is not below the destination. It produces, one gate at a time, an ordered list of Toffoli gates with positive controls. Applied in order, these gates turn the source pattern into the destination pattern. No pattern that is numerically smaller than the destination is disturbed. A synthesis engine that walks a truth table row by row calls the block once for each row that needs fixing.

The block first finds a control set. It starts from the source pattern and drops its least significant ones for as long as the value does not fall below the destination. It then emits gates in two phases, and each phase uses its own control mask. Each gate leaves the block on a valid/ready handshake. A one-cycle done pulse closes every request, and an error indication goes with that pulse when the source is below the destination.

Top module: `tgm_row_mapper`

## Requirements
- R1: When the source equals the destination, no gate is emitted. `seq_done` rises in the first cycle after the request is accepted, and `seq_err` stays low.
- R2: When the source is numerically below the destination, no gate is emitted. `seq_done` and `seq_err` are both high in the first cycle after acceptance. `seq_err` is never high without `seq_done`.
- R3: The control mask of the first phase is the source pattern with its lowest set bits cleared one at a time. Clearing stops at the last value that is still greater than or equal to the destination, and that value may be zero.
- R4: The first phase emits one gate for each set bit of (source XOR destination) AND NOT mask. Each gate has `gate_ctrl` equal to the pruned mask, and the targets come in ascending bit order.
- R5: The second phase follows the first. It emits one gate for each set bit of mask AND NOT destination, with `gate_ctrl` equal to the destination pattern and targets in ascending order.
- R6: In `gate_ctrl`, a 1 in bit i means a positive control on line i; there are no negative controls. The bit at the target index is always 0.
- R7: While `gate_valid` is high and `gate_ready` is low, `gate_valid`, `gate_ctrl` and `gate_tgt` hold their values into the next cycle.
- R8: `seq_done` is a one-cycle pulse that follows the last accepted gate. `req_ready` is high after reset and after done, and low from acceptance until done. A request offered while the block is busy is ignored.
- R9: The first gate, or the done pulse, appears no later than the (WIDTH+4)th cycle after acceptance. Pruning removes at most one bit per cycle.
- R10: Applying every emitted gate in order to the source pattern yields the destination pattern. A gate flips bit `gate_tgt` when all bits of `gate_ctrl` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_src | input | WIDTH | Source pattern (the output side of the row) |
| req_dst | input | WIDTH | Destination pattern (the row index) |
| gate_valid | output | 1 | A gate is presented |
| gate_ready | input | 1 | Consumer takes the gate |
| gate_ctrl | output | WIDTH | Positive-control mask of the gate |
| gate_tgt | output | $clog2(WIDTH) | Target line index |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| seq_err | output | 1 | Source below destination, valid with seq_done |

## Verification
Equal pairs (all zeros, all ones, a mixed value) separate the empty sequence from a pruning pass that wrongly emits gates. Reversed pairs separate error detection from a plain unsigned comparison. All ones down to zero prunes the mask to nothing and gives eight uncontrolled gates. A single high bit down to all lower ones stops pruning at once and needs both phases, which exposes swapped phase masks. Random pairs are run with random stalls on the gate consumer; the bench replays every gate on a running pattern and checks that it lands on the destination.

// File: rtl/tgm_pkg.sv
package tgm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PRUNE = 3'd1,
      ST_PH1   = 3'd2,
      ST_PH2   = 3'd3,
      ST_FIN   = 3'd4
   } tgm_state_e;

   function automatic int unsigned idx_width(input int unsigned w);
      return (w > 1) ? $clog2(w) : 1;
   endfunction

endpackage

// File: rtl/tgm_low_pick.sv
// Finds the least significant set bit of a vector: its index, a flag that
// any bit is set, and the vector with that bit removed.
module tgm_low_pick #(
   parameter int WIDTH = 8,
   parameter int IDXW  = 3
) (
   input  logic [WIDTH-1:0] vec,
   output logic             found,
   output logic [IDXW-1:0]  idx,
   output logic [WIDTH-1:0] rest
);

   logic [WIDTH-1:0] seen_below;
   logic [WIDTH-1:0] first_hot;

   assign seen_below[0] = 1'b0;

   genvar gi;
   generate
      for (gi = 1; gi < WIDTH; gi++) begin : g_chain
         assign seen_below[gi] = seen_below[gi-1] | vec[gi-1];
      end
      for (gi = 0; gi < WIDTH; gi++) begin : g_hot
         assign first_hot[gi] = vec[gi] & ~seen_below[gi];
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (first_hot[i]) idx = idx | IDXW'(i);
      end
   end

   assign found = |vec;
   assign rest  = vec & ~first_hot;

endmodule

// File: rtl/tgm_prune_step.sv
// One pruning step: clears the lowest set bit of the mask and reports
// whether the reduced mask still reaches the floor pattern.
module tgm_prune_step #(
   parameter int WIDTH = 8,
   parameter int IDXW  = 3
) (
   input  logic [WIDTH-1:0] mask,
   input  logic [WIDTH-1:0] floor_pat,
   output logic [WIDTH-1:0] next_mask,
   output logic             keep_going
);

   logic            any_bit;
   logic [IDXW-1:0] unused_idx;

   tgm_low_pick #(
      .WIDTH (WIDTH),
      .IDXW  (IDXW)
   ) u_pick (
      .vec   (mask),
      .found (any_bit),
      .idx   (unused_idx),
      .rest  (next_mask)
   );

   assign keep_going = any_bit && (next_mask >= floor_pat);

endmodule

// File: rtl/tgm_row_mapper.sv
module tgm_row_mapper #(
   parameter int WIDTH = 8,
   parameter int IDXW  = tgm_pkg::idx_width(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [WIDTH-1:0] req_src,
   input  logic [WIDTH-1:0] req_dst,
   output logic             gate_valid,
   input  logic             gate_ready,
   output logic [WIDTH-1:0] gate_ctrl,
   output logic [IDXW-1:0]  gate_tgt,
   output logic             seq_done,
   output logic             seq_err
);
   import tgm_pkg::*;

   localparam logic [WIDTH-1:0] ZERO_PAT = '0;

   generate
      if (WIDTH < 2 || WIDTH > 16) begin : g_bad_width
         $error("tgm_row_mapper: WIDTH must lie in 2..16");
      end
      if (IDXW < $clog2(WIDTH)) begin : g_bad_idx
         $error("tgm_row_mapper: IDXW too narrow for WIDTH");
      end
   endgenerate

   tgm_state_e       state_q;
   logic [WIDTH-1:0] src_q;
   logic [WIDTH-1:0] dst_q;
   logic [WIDTH-1:0] mask_q;
   logic [WIDTH-1:0] pend_q;
   logic             err_q;

   logic [WIDTH-1:0] prune_next;
   logic             prune_more;
   logic             pend_any;
   logic [IDXW-1:0]  pend_idx;
   logic [WIDTH-1:0] pend_rest;
   logic             accept;
   logic             emit_fire;
   logic             in_phase;

   tgm_prune_step #(
      .WIDTH (WIDTH),
      .IDXW  (IDXW)
   ) u_prune (
      .mask       (mask_q),
      .floor_pat  (dst_q),
      .next_mask  (prune_next),
      .keep_going (prune_more)
   );

   tgm_low_pick #(
      .WIDTH (WIDTH),
      .IDXW  (IDXW)
   ) u_target (
      .vec   (pend_q),
      .found (pend_any),
      .idx   (pend_idx),
      .rest  (pend_rest)
   );

   assign req_ready  = (state_q == ST_IDLE);
   assign accept     = req_valid && req_ready;
   assign in_phase   = (state_q == ST_PH1) || (state_q == ST_PH2);
   assign gate_valid = in_phase && pend_any;
   assign emit_fire  = gate_valid && gate_ready;
   assign gate_ctrl  = (state_q == ST_PH2) ? dst_q : mask_q;
   assign gate_tgt   = pend_idx;
   assign seq_done   = (state_q == ST_FIN);
   assign seq_err    = (state_q == ST_FIN) && err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         src_q   <= ZERO_PAT;
         dst_q   <= ZERO_PAT;
         mask_q  <= ZERO_PAT;
         pend_q  <= ZERO_PAT;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  src_q  <= req_src;
                  dst_q  <= req_dst;
                  mask_q <= req_src;
                  pend_q <= ZERO_PAT;
                  if (req_src == req_dst) begin
                     err_q   <= 1'b0;
                     state_q <= ST_FIN;
                  end else if (req_src < req_dst) begin
                     err_q   <= 1'b1;
                     state_q <= ST_FIN;
                  end else begin
                     err_q   <= 1'b0;
                     state_q <= ST_PRUNE;
                  end
               end
            end
            ST_PRUNE: begin
               if (prune_more) begin
                  mask_q <= prune_next;
               end else begin
                  pend_q  <= (src_q ^ dst_q) & ~mask_q;
                  state_q <= ST_PH1;
               end
            end
            ST_PH1: begin
               if (!pend_any) begin
                  pend_q  <= mask_q & ~dst_q;
                  state_q <= ST_PH2;
               end else if (emit_fire) begin
                  pend_q <= pend_rest;
               end
            end
            ST_PH2: begin
               if (!pend_any) begin
                  state_q <= ST_FIN;
               end else if (emit_fire) begin
                  pend_q <= pend_rest;
               end
            end
            ST_FIN: begin
               err_q   <= 1'b0;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tgm_row_mapper_chk.sv
module tgm_row_mapper_chk #(
   parameter int WIDTH = 8,
   parameter int IDXW  = tgm_pkg::idx_width(WIDTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [WIDTH-1:0] req_src,
   input logic [WIDTH-1:0] req_dst,
   input logic             gate_valid,
   input logic             gate_ready,
   input logic [WIDTH-1:0] gate_ctrl,
   input logic [IDXW-1:0]  gate_tgt,
   input logic             seq_done,
   input logic             seq_err
);

   logic        acc;
   logic        waiting_q;
   logic [15:0] wait_cnt_q;

   assign acc = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waiting_q  <= 1'b0;
         wait_cnt_q <= '0;
      end else if (acc) begin
         waiting_q  <= 1'b1;
         wait_cnt_q <= '0;
      end else if (waiting_q) begin
         if (gate_valid || seq_done) waiting_q <= 1'b0;
         else                         wait_cnt_q <= wait_cnt_q + 16'd1;
      end
   end

   assert_equal_is_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (req_src == req_dst)) |=> (seq_done && !seq_err && !gate_valid));

   assert_reversed_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (req_src < req_dst)) |=> (seq_done && seq_err && !gate_valid));

   assert_err_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |-> seq_done);

   assert_target_not_control_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gate_valid |-> (gate_ctrl[gate_tgt] == 1'b0));

   assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_valid && !gate_ready) |=>
         (gate_valid && $stable(gate_ctrl) && $stable(gate_tgt)));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> (!seq_done && req_ready));

   assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gate_valid |-> !req_ready);

   assert_first_result_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      waiting_q |-> (wait_cnt_q <= 16'(WIDTH + 4)));

endmodule

bind tgm_row_mapper tgm_row_mapper_chk #(
   .WIDTH (WIDTH),
   .IDXW  (IDXW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_src    (req_src),
   .req_dst    (req_dst),
   .gate_valid (gate_valid),
   .gate_ready (gate_ready),
   .gate_ctrl  (gate_ctrl),
   .gate_tgt   (gate_tgt),
   .seq_done   (seq_done),
   .seq_err    (seq_err)
);

// File: tb/test_tgm_row_mapper.sv
module test_tgm_row_mapper;

   localparam int W  = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic          req_ready;
   logic [W-1:0]  req_src;
   logic [W-1:0]  req_dst;
   logic          gate_valid;
   logic          gate_ready;
   logic [W-1:0]  gate_ctrl;
   logic [IW-1:0] gate_tgt;
   logic          seq_done;
   logic          seq_err;

   always #2 clk = ~clk;

   tgm_row_mapper #(.WIDTH(W)) i_tgm_row_mapper (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_src    (req_src),
      .req_dst    (req_dst),
      .gate_valid (gate_valid),
      .gate_ready (gate_ready),
      .gate_ctrl  (gate_ctrl),
      .gate_tgt   (gate_tgt),
      .seq_done   (seq_done),
      .seq_err    (seq_err)
   );

   typedef struct packed {
      logic          ph2;
      logic [W-1:0]  ctrl;
      logic [IW-1:0] tgt;
   } exp_gate_t;

   exp_gate_t    exp_q[$];
   logic [W-1:0] run_pat;
   int           n_vec = 0;
   int           n_bad = 0;
   bit           stall_en = 1'b0;
   logic [15:0]  lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [15:0] lfsr_next(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   // consumer ready pattern
   initial begin
      gate_ready = 1'b1;
      forever begin
         @(posedge clk);
         #1;
         lfsr = lfsr_next(lfsr);
         gate_ready = stall_en ? lfsr[3] : 1'b1;
      end
   end

   // monitor: stability, ordering and scoreboard compare
   initial begin : monitor
      logic          pv, pr;
      logic [W-1:0]  pc;
      logic [IW-1:0] pt;
      pv = 1'b0; pr = 1'b1; pc = '0; pt = '0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            pv = 1'b0;
         end else begin
            if (pv && !pr) begin
               chk(gate_valid && gate_ctrl == pc && gate_tgt == pt, "R7",
                   "gate held under stall", {gate_ctrl, 5'd0, gate_tgt}, {pc, 5'd0, pt});
            end
            if (gate_valid) begin
               chk(!req_ready, "R8", "ready low while busy", 32'(req_ready), 32'd0);
               chk(gate_ctrl[gate_tgt] == 1'b0, "R6", "target outside controls",
                   32'(gate_ctrl), 32'(gate_tgt));
            end
            if (gate_valid && gate_ready) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R4", "unexpected extra gate", {gate_ctrl, 5'd0, gate_tgt}, 32'd0);
               end else begin
                  exp_gate_t e;
                  e = exp_q.pop_front();
                  if (e.ph2)
                     chk(gate_ctrl == e.ctrl && gate_tgt == e.tgt, "R5",
                         "phase two gate", {gate_ctrl, 5'd0, gate_tgt}, {e.ctrl, 5'd0, e.tgt});
                  else
                     chk(gate_ctrl == e.ctrl && gate_tgt == e.tgt, "R3 R4",
                         "phase one gate", {gate_ctrl, 5'd0, gate_tgt}, {e.ctrl, 5'd0, e.tgt});
               end
               if ((run_pat & gate_ctrl) == gate_ctrl) run_pat[gate_tgt] = ~run_pat[gate_tgt];
            end
            pv = gate_valid; pr = gate_ready; pc = gate_ctrl; pt = gate_tgt;
         end
      end
   end

   // driver: builds the expected stream from the requirements, then requests
   task automatic run_case(input logic [W-1:0] y, input logic [W-1:0] x);
      logic [W-1:0] c, cand, p, q;
      bit           eerr, first;
      int           lat;
      eerr = (y < x);
      exp_q.delete();
      if (y > x) begin
         c = y;
         while (c != '0) begin
            cand = c & (c - 1'b1);
            if (cand >= x) c = cand;
            else break;
         end
         p = (x ^ y) & ~c;
         q = c & ~x;
         for (int j = 0; j < W; j++)
            if (p[j]) exp_q.push_back({1'b0, c, IW'(j)});
         for (int j = 0; j < W; j++)
            if (q[j]) exp_q.push_back({1'b1, x, IW'(j)});
      end
      run_pat = y;
      @(posedge clk);
      #1;
      req_valid = 1'b1;
      req_src   = y;
      req_dst   = x;
      @(posedge clk);
      #1;
      // keep offering unrelated data while busy: must be ignored (R8)
      req_src = ~y;
      req_dst = y ^ 8'h5A;
      lat = 0;
      first = 1'b0;
      forever begin
         @(negedge clk);
         lat++;
         if (!first && (gate_valid || seq_done)) begin
            first = 1'b1;
            chk(lat <= W + 4, "R9", "first result latency", 32'(lat), 32'(W + 4));
         end
         if (seq_done) break;
         if (lat > 3000) begin
            chk(1'b0, "R8", "done never arrived", 32'(lat), 32'd0);
            break;
         end
      end
      req_valid = 1'b0;
      chk(seq_err == eerr, "R2", "error flag", 32'(seq_err), 32'(eerr));
      chk(exp_q.size() == 0, "R4", "missing gates", 32'(exp_q.size()), 32'd0);
      if (y == x) chk(lat == 1, "R1", "done latency on equal", 32'(lat), 32'd1);
      if (y < x)  chk(lat == 1, "R2", "done latency on reversed", 32'(lat), 32'd1);
      if (!eerr)  chk(run_pat == x, "R10", "replayed gates reach destination",
                      32'(run_pat), 32'(x));
      @(negedge clk);
      chk(!seq_done && req_ready, "R8", "done is a pulse, ready returns",
          {30'd0, seq_done, req_ready}, 32'd1);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin : main
      logic [15:0] r;
      logic [W-1:0] a, b;
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_src   = '0;
      req_dst   = '0;
      repeat (3) @(negedge clk);
      chk(req_ready && !gate_valid && !seq_done && !seq_err, "R8", "reset state",
          {28'd0, req_ready, gate_valid, seq_done, seq_err}, 32'h8);
      @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: equal patterns
      run_case(8'h00, 8'h00);
      run_case(8'h5A, 8'h5A);
      run_case(8'hFF, 8'hFF);
      // R2: reversed patterns
      run_case(8'h03, 8'h07);
      run_case(8'h00, 8'h80);
      run_case(8'h7F, 8'h80);
      // R3/R4/R5 directed
      run_case(8'hFF, 8'h00);
      run_case(8'h80, 8'h7F);
      run_case(8'h07, 8'h01);
      run_case(8'hB4, 8'h93);
      run_case(8'h01, 8'h00);

      // random pairs with stalls (R7)
      stall_en = 1'b1;
      r = 16'h1D2B;
      for (int k = 0; k < 300; k++) begin
         r = lfsr_next(r); a = r[7:0];
         r = lfsr_next(r); b = r[15:8];
         r = lfsr_next(r);
         if (r[0] && a < b) run_case(b, a);
         else               run_case(a, b);
      end
      stall_en = 1'b0;

      summary();
      $finish;
   end

endmodule